// File: doc/BRIEF.md
# Heartbeat Watchdog with Pulse and Latched Fault Outputs

This block watches a heartbeat line driven by a processor and reports a software fault when the line stops moving. The line arrives as two digital bits: its logic level and a flag that is raised when the line is left floating. Both bits are synchronized. Any change of the synchronized level counts as activity and restarts the timeout. A short high or low pulse is two such changes, so it also counts.

When the timeout runs out, an active-low fault pulse is driven for a fixed minimum number of cycles. One cycle after the pulse falls, an active-low fault level goes low. That level stays low until the next activity on the heartbeat. A single quiet stretch gives only one pulse: a new pulse needs a transition and then another full timeout.

The watchdog is disabled, with both outputs held high, in four cases: the heartbeat is floating, the supervisor reset is active, the system runs from backup power, or a counter-clear pulse arrives. The timeout length is a parameter. A runtime select chooses between the default length and an alternative length.

Top module: `hb_watchdog`

## Requirements
- R1: While `rst_n` is low, and after its release while `sup_reset` is high, `fault_pulse_n` and `fault_lvl_n` are both 1.
- R2: A change of the heartbeat level in either direction restarts the timeout. A transition seen at a clock edge also drives `fault_lvl_n` to 1 after that edge. While the level keeps changing more often than once per timeout, `fault_pulse_n` never falls.
- R3: A heartbeat pulse only one clock wide restarts the timeout.
- R4: With `period_sel` = 0, `fault_pulse_n` falls SYNC_STAGES+TIMEOUT_DEF+1 clock edges after the last heartbeat change, counted from the edge after the input changed. It then stays 0 for exactly PULSE_W cycles.
- R5: `fault_lvl_n` falls one cycle after `fault_pulse_n` falls. It stays 0 until the next heartbeat transition, and goes back to 1 SYNC_STAGES+1 edges after that transition is applied.
- R6: After a fault, no further pulse occurs while the heartbeat stays constant.
- R7: With `period_sel` = 1, the timeout is TIMEOUT_ALT cycles instead of TIMEOUT_DEF.
- R8: While the synchronized `hb_float` is 1, the timer is held and both outputs are 1. This includes a fault level that was already latched.
- R9: `sup_reset` = 1 or `on_battery` = 1 forces both outputs to 1 after the next edge and holds the timer cleared.
- R10: A one-cycle `clr_pulse` forces both outputs to 1 and clears the timer. The next pulse then follows TIMEOUT_DEF+1 edges after the clear was applied.
- R11: A heartbeat transition during the fault pulse does not shorten the pulse, but it releases the fault level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| sup_reset | input | 1 | Supervisor reset active; disables the watchdog |
| on_battery | input | 1 | Backup-power mode; disables the watchdog |
| clr_pulse | input | 1 | Counter-clear pulse; clears the timer and forces the outputs high |
| period_sel | input | 1 | 0 selects TIMEOUT_DEF, 1 selects TIMEOUT_ALT |
| hb_level | input | 1 | Heartbeat logic level (asynchronous) |
| hb_float | input | 1 | Heartbeat-floating flag (asynchronous) |
| fault_pulse_n | output | 1 | Active-low fault pulse, PULSE_W cycles wide |
| fault_lvl_n | output | 1 | Active-low latched fault level |

## Verification
Four properties are checked on every cycle: any disable condition forces both outputs high on the next edge, an uninterrupted pulse has exactly PULSE_W low cycles, the fault level only falls right after a pulse cycle and then holds until activity, and every detected transition releases the level. Other behaviours can only be shown by the bench's scenarios. These are the exact timeout lengths under both period selects, single-shot behaviour over long quiet stretches, one-cycle heartbeat pulses, and the timing of the restart after a counter-clear. The bench's cycle model covers these, together with its directed measurements.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  // Timeout length in cycles for the selected period.
  function automatic int unsigned hbw_limit(input logic sel,
                                            input int unsigned def_len,
                                            input int unsigned alt_len);
    return sel ? alt_len : def_len;
  endfunction

  // Larger of two lengths, used to size the idle counter.
  function automatic int unsigned hbw_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d[g];
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d[g]};
      end
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/hbw_timer.sv
module hbw_timer
  import hbw_pkg::*;
#(
  parameter int unsigned TIMEOUT_DEF = 1600000,
  parameter int unsigned TIMEOUT_ALT = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic restart,
  input  logic sel,
  output logic expire
);
  localparam int unsigned MAXLEN = hbw_max(TIMEOUT_DEF, TIMEOUT_ALT);
  localparam int CW = $clog2(MAXLEN + 1);

  logic [CW-1:0] idle_cnt;
  logic          fired;
  logic [CW-1:0] last_idx;

  assign last_idx = CW'(hbw_limit(sel, TIMEOUT_DEF, TIMEOUT_ALT) - 1);
  assign expire   = !hold && !restart && !fired && (idle_cnt >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      fired    <= 1'b0;
    end else if (hold || restart) begin
      idle_cnt <= '0;
      fired    <= 1'b0;
    end else if (expire) begin
      idle_cnt <= '0;
      fired    <= 1'b1;
    end else if (!fired) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbw_fault.sv
module hbw_fault #(
  parameter int unsigned PULSE_W = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic restart,
  input  logic expire,
  output logic pulse_n,
  output logic lvl_n
);
  localparam int PW = $clog2(PULSE_W + 1);

  logic [PW-1:0] remain;
  logic          pend;
  logic          lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      pend   <= 1'b0;
      lvl_q  <= 1'b0;
    end else if (hold) begin
      remain <= '0;
      pend   <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      if (expire)           remain <= PW'(PULSE_W);
      else if (remain != 0) remain <= remain - 1'b1;
      pend <= expire;
      if (restart)   lvl_q <= 1'b0;
      else if (pend) lvl_q <= 1'b1;
    end
  end

  assign pulse_n = (remain == '0);
  assign lvl_n   = !lvl_q;
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_DEF = 1600000,
  parameter int unsigned TIMEOUT_ALT = 400000,
  parameter int unsigned PULSE_W     = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_reset,
  input  logic on_battery,
  input  logic clr_pulse,
  input  logic period_sel,
  input  logic hb_level,
  input  logic hb_float,
  output logic fault_pulse_n,
  output logic fault_lvl_n
);
  logic [1:0] sync_q;
  logic       lvl_s;
  logic       float_s;
  logic       lvl_prev;
  logic       hb_edge;
  logic       wd_hold;
  logic       expire;

  hbw_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({hb_float, hb_level}), .q(sync_q)
  );
  assign lvl_s   = sync_q[0];
  assign float_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl_s;
  end

  assign hb_edge = lvl_s ^ lvl_prev;
  assign wd_hold = sup_reset | on_battery | clr_pulse | float_s;

  hbw_timer #(.TIMEOUT_DEF(TIMEOUT_DEF), .TIMEOUT_ALT(TIMEOUT_ALT)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(wd_hold), .restart(hb_edge),
    .sel(period_sel), .expire(expire)
  );

  hbw_fault #(.PULSE_W(PULSE_W)) u_fault (
    .clk(clk), .rst_n(rst_n), .hold(wd_hold), .restart(hb_edge),
    .expire(expire), .pulse_n(fault_pulse_n), .lvl_n(fault_lvl_n)
  );
endmodule

// File: rtl/hbw_checker.sv
module hbw_checker #(
  parameter int unsigned PULSE_W = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic restart,
  input logic pulse_n,
  input logic lvl_n
);
  localparam int LW = $clog2(PULSE_W + 2);
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (!pulse_n) low_run <= low_run + 1'b1;
    else               low_run <= '0;
  end

  // R8, R9, R10: any disable source quiets both outputs on the next edge.
  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pulse_n && lvl_n));

  // R4: an uninterrupted pulse lasts exactly PULSE_W cycles.
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pulse_n) && !$past(hold)) |-> (low_run == LW'(PULSE_W)));

  // R5: the level only falls right after a pulse cycle.
  p_lvl_after_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_n) |-> $past(!pulse_n));

  // R5: the latched level holds until activity or disable.
  p_lvl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_n && !restart && !hold) |=> !lvl_n);

  // R2: every detected transition releases the level.
  p_edge_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> lvl_n);
endmodule

bind hb_watchdog hbw_checker #(.PULSE_W(PULSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(wd_hold), .restart(hb_edge),
  .pulse_n(fault_pulse_n), .lvl_n(fault_lvl_n)
);

// File: tb/tb_hb_watchdog.sv
module tb_hb_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int S   = 2;
  localparam int TD  = 40;
  localparam int TA  = 25;
  localparam int PWD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_reset = 1'b1, on_battery = 1'b0, clr_pulse = 1'b0, period_sel = 1'b0;
  logic hb_level = 1'b0, hb_float = 1'b0;
  logic fault_pulse_n, fault_lvl_n;

  int checks = 0, fails = 0, falls = 0;
  bit finished = 0;
  logic prev_p = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_watchdog #(.SYNC_STAGES(S), .TIMEOUT_DEF(TD), .TIMEOUT_ALT(TA), .PULSE_W(PWD)) dut (
    .clk(clk), .rst_n(rst_n), .sup_reset(sup_reset), .on_battery(on_battery),
    .clr_pulse(clr_pulse), .period_sel(period_sel), .hb_level(hb_level),
    .hb_float(hb_float), .fault_pulse_n(fault_pulse_n), .fault_lvl_n(fault_lvl_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: delayed input samples, idle count, fault timers.
  logic [S-1:0] m_lv = '0, m_fl = '0;
  logic m_prev = 0, m_fired = 0, m_pend = 0, m_lvl = 0;
  int m_idle = 0, m_prem = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lv = '0; m_fl = '0; m_prev = 0; m_fired = 0; m_pend = 0; m_lvl = 0;
      m_idle = 0; m_prem = 0;
    end else begin
      bit act, quiet, tmo;
      int lim;
      act   = (m_lv[S-1] != m_prev);
      quiet = sup_reset || on_battery || clr_pulse || m_fl[S-1];
      lim   = period_sel ? TA : TD;
      tmo   = !quiet && !act && !m_fired && (m_idle >= lim - 1);
      if (quiet) begin
        m_prem = 0; m_pend = 0; m_lvl = 0;
      end else begin
        if (act) m_lvl = 0; else if (m_pend) m_lvl = 1;
        m_pend = tmo;
        if (tmo) m_prem = PWD; else if (m_prem > 0) m_prem--;
      end
      if (quiet || act) begin m_idle = 0; m_fired = 0; end
      else if (tmo) begin m_idle = 0; m_fired = 1; end
      else if (!m_fired) m_idle++;
      m_prev = m_lv[S-1];
      m_lv = {m_lv[S-2:0], hb_level};
      m_fl = {m_fl[S-2:0], hb_float};
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(fault_pulse_n == (m_prem == 0), "R4", "model pulse", fault_pulse_n, m_prem == 0);
      check(fault_lvl_n == !m_lvl, "R5", "model level", fault_lvl_n, !m_lvl);
      if (prev_p && !fault_pulse_n) falls++;
      prev_p = fault_pulse_n;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (fault_pulse_n && n < 1000);
  endtask

  // Measures pulse width starting at the fall; returns level at fall and one later.
  task automatic measure(output int len, output bit lv0, output bit lv1);
    len = 1; lv0 = fault_lvl_n;
    @(negedge clk); lv1 = fault_lvl_n;
    while (!fault_pulse_n && len < 1000) begin len++; @(negedge clk); end
  endtask

  task automatic report;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected done");
    report();
  end

  initial begin
    int n, len, f0;
    bit a, b;
    tick(3);
    check(fault_pulse_n && fault_lvl_n, "R1", "outputs in rst_n", {fault_pulse_n, fault_lvl_n}, 3);
    rst_n = 1'b1;
    tick(3 * TD);
    check(fault_pulse_n && fault_lvl_n && falls == 0, "R1", "outputs under sup_reset",
          {fault_pulse_n, fault_lvl_n}, 3);
    sup_reset = 1'b0;

    // R2: regular toggling keeps the pulse away.
    for (int i = 0; i < 15; i++) begin hb_level = ~hb_level; tick(TD / 2); end
    check(falls == 0, "R2", "pulses while toggling", falls, 0);

    // R4 / R5: timeout length, pulse width, level delay.
    hb_level = ~hb_level;
    wait_fall(n);
    check(n == S + TD + 1, "R4", "default timeout edges", n, S + TD + 1);
    measure(len, a, b);
    check(len == PWD, "R4", "pulse width", len, PWD);
    check(a == 1 && b == 0, "R5", "level one cycle after pulse", {a, b}, 2);

    // R6: single shot, level held.
    f0 = falls;
    tick(3 * TD);
    check(falls == f0, "R6", "extra pulses", falls - f0, 0);
    check(fault_lvl_n == 0, "R5", "level held", fault_lvl_n, 0);

    // R5 release timing.
    hb_level = ~hb_level;
    tick(S);
    check(fault_lvl_n == 0, "R5", "level before release", fault_lvl_n, 0);
    tick(1);
    check(fault_lvl_n == 1, "R5", "level after release", fault_lvl_n, 1);

    // R3: one-cycle heartbeat pulses.
    f0 = falls;
    for (int i = 0; i < 8; i++) begin
      tick(TD - 10); hb_level = ~hb_level; tick(1); hb_level = ~hb_level;
    end
    check(falls == f0, "R3", "pulses with narrow heartbeats", falls - f0, 0);

    // R7: alternative period.
    tick(TD + 10);
    period_sel = 1'b1;
    hb_level = ~hb_level;
    wait_fall(n);
    check(n == S + TA + 1, "R7", "alternative timeout edges", n, S + TA + 1);
    tick(PWD + 2);
    period_sel = 1'b0;

    // R8: floating input releases the latched level and holds the timer.
    check(fault_lvl_n == 0, "R8", "level latched before float", fault_lvl_n, 0);
    hb_float = 1'b1;
    tick(S + 1);
    check(fault_lvl_n == 1 && fault_pulse_n == 1, "R8", "outputs while floating",
          {fault_pulse_n, fault_lvl_n}, 3);
    f0 = falls;
    tick(3 * TD);
    check(falls == f0, "R8", "pulses while floating", falls - f0, 0);
    hb_float = 1'b0;

    // R9: backup power during a fault level.
    wait_fall(n);
    tick(PWD + 2);
    on_battery = 1'b1;
    tick(1);
    check(fault_lvl_n == 1, "R9", "level under backup power", fault_lvl_n, 1);
    f0 = falls;
    tick(2 * TD);
    check(falls == f0, "R9", "pulses under backup power", falls - f0, 0);
    on_battery = 1'b0;

    // R10: clear during a pulse, then a fresh timeout.
    wait_fall(n);
    tick(2);
    clr_pulse = 1'b1;
    tick(1);
    clr_pulse = 1'b0;
    check(fault_pulse_n == 1 && fault_lvl_n == 1, "R10", "outputs after clear",
          {fault_pulse_n, fault_lvl_n}, 3);
    wait_fall(n);
    check(n == TD, "R10", "edges to next pulse after clear", n + 1, TD + 1);

    // R11: transition during the pulse.
    tick(PWD + 2);
    hb_level = ~hb_level;
    tick(1);
    wait_fall(n);
    hb_level = ~hb_level;
    measure(len, a, b);
    check(len == PWD, "R11", "pulse width with transition", len, PWD);
    tick(2);
    check(fault_lvl_n == 1, "R11", "level released", fault_lvl_n, 1);

    report();
  end
endmodule